// File: doc/BRIEF.md
# Fan PWM Duty Ramp Controller

This block drives a single fan PWM pin. The duty it applies, a 10-bit level, moves toward a requested value in programmable steps. A small register file holds the settings: source mode, spin-up level, stop level, up and down step sizes, clock prescaler and control flags. In the two automatic modes the requested value comes from one of two external inputs. One stands for the result of a speed loop and the other for the result of a temperature loop. In manual mode the duty comes straight from a third input.

A stopped fan is kicked to the spin-up level instead of crawling up from zero. A fan being shut down ramps to the stop level and then cuts to zero, unless a hold flag keeps it parked at the stop level. A full-speed flag overrides everything. The duty is re-evaluated once per PWM period. A new value reaches the pin only at the start of a period, so no runt pulse appears.

Top module: `fan_duty_ctrl`

## Requirements
- R1: After reset the duty is 0 and the pin is low. The register defaults are: control 00h, spin-up level 30h, stop level 25h, frequency 80h, step 00h. Register addresses are 0 control, 1 spin-up level, 2 stop level, 3 frequency, 4 step. Levels are the duty's bits [9:2], with bits [1:0] read as zero.
- R2: Control bits [1:0] select the source. 00 follows `speed_target`, 01 follows `temp_target`, and 1x applies `manual_duty` unchanged at the next period boundary, with no ramp and no jumps.
- R3: In an automatic mode, with duty 0 and a request that is nonzero and at or above the stop level, the next boundary sets the duty to the spin-up level.
- R4: When the request is above a nonzero duty, each boundary adds the up step (step bits [7:4]) and never passes the request.
- R5: When the request is at or above the stop level and below the duty, each boundary subtracts the down step (step bits [3:0]) and never passes below the request.
- R6: When the request is 0 or below the stop level, the duty ramps down to the stop level. At the boundary after it reaches that level it drops to 0. A duty of 0 stays 0 under such a request.
- R7: With the hold flag (control bit 2) set, a duty that has reached the stop level under a shut-down request stays there.
- R8: A step value of 0 moves the duty all the way to its goal in a single boundary, in either direction.
- R9: With the full-speed flag (control bit 3) set, the next boundary sets the duty to 3FFh in any mode.
- R10: The duty changes only at period boundaries. An 8-bit counter runs through each period, and the pin is high while the counter is below duty bits [9:2].
- R11: A period lasts base × max(div,1) × 256 clocks. Here div is frequency bits [6:0], and base is FAST_CYC when frequency bit 7 is 1 and SLOW_CYC when it is 0.
- R12: Control bit 4 (analog-drive select) is stored but has no effect on the duty or the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| speed_target | input | 10 | Requested duty from the speed loop |
| temp_target | input | 10 | Requested duty from the temperature loop |
| manual_duty | input | 10 | Software-set duty |
| pwm_out | output | 1 | Fan PWM pin |
| duty_level | output | 10 | Duty applied in the current period |

## Verification
A wrong duty register shows on `duty_level` at once. It shows on the pin as a wrong high-time count within one period. A fault in the ramp arithmetic surfaces only at a boundary, so every check samples the cycle just after the 256th counter tick. Near-miss values around the saturation points are the ones compared, such as 1FBh then 1F0h, not 1ECh. A prescaler fault does not alter the duty. It stretches or shortens the interval between rising pin edges, so the divider checks measure that interval directly.

// File: rtl/fan_ramp_pkg.sv
package fan_ramp_pkg;
  localparam int DUTY_W = 10;
  localparam int REG_W  = 8;
  localparam int STEP_W = 4;
  localparam int ADDR_W = 3;
  localparam int LOW_W  = DUTY_W - REG_W;

  localparam logic [REG_W-1:0] START_RST = 8'h30;
  localparam logic [REG_W-1:0] STOP_RST  = 8'h25;
  localparam logic [REG_W-1:0] FREQ_RST  = 8'h80;
  localparam logic [REG_W-1:0] STEP_RST  = 8'h00;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_START = 3'd1;
  localparam logic [ADDR_W-1:0] A_STOP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FREQ  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STEP  = 3'd4;

  typedef struct packed {
    logic       dc_sel;
    logic       full_latch;
    logic       keep_stop;
    logic [1:0] mode;
  } ctrl_t;

  function automatic logic [DUTY_W-1:0] widen(input logic [REG_W-1:0] lvl);
    return {lvl, {LOW_W{1'b0}}};
  endfunction

  // Move cur toward goal by the matching step; zero step jumps straight there.
  function automatic logic [DUTY_W-1:0] step_toward(
      input logic [DUTY_W-1:0] cur, input logic [DUTY_W-1:0] goal,
      input logic [STEP_W-1:0] up, input logic [STEP_W-1:0] dn);
    logic [DUTY_W:0] sum;
    logic [DUTY_W:0] gap;
    sum = {1'b0, cur} + {{(DUTY_W-STEP_W+1){1'b0}}, up};
    gap = {1'b0, cur} - {1'b0, goal};
    if (goal > cur) begin
      if (up == '0 || sum >= {1'b0, goal}) return goal;
      return sum[DUTY_W-1:0];
    end else if (goal < cur) begin
      if (dn == '0 || gap <= {{(DUTY_W-STEP_W+1){1'b0}}, dn}) return goal;
      return cur - {{(DUTY_W-STEP_W){1'b0}}, dn};
    end
    return cur;
  endfunction

  // One boundary of the automatic ramp, including spin-up and shut-down jumps.
  function automatic logic [DUTY_W-1:0] ramp_next(
      input logic [DUTY_W-1:0] cur, input logic [DUTY_W-1:0] req,
      input logic [DUTY_W-1:0] start_lv, input logic [DUTY_W-1:0] stop_lv,
      input logic [STEP_W-1:0] up, input logic [STEP_W-1:0] dn,
      input logic keep);
    logic run;
    run = (req != '0) && (req >= stop_lv);
    if (run) begin
      if (cur == '0) return start_lv;
      return step_toward(cur, req, up, dn);
    end
    if (cur == '0) return '0;
    if (cur > stop_lv) return step_toward(cur, stop_lv, up, dn);
    return keep ? cur : '0;
  endfunction
endpackage

// File: rtl/fan_cfg_regs.sv
module fan_cfg_regs
  import fan_ramp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output ctrl_t             ctrl_q,
  output logic [REG_W-1:0]  start_q,
  output logic [REG_W-1:0]  stop_q,
  output logic [REG_W-1:0]  freq_q,
  output logic [REG_W-1:0]  step_q
);
  localparam int CTRL_W = $bits(ctrl_t);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      start_q <= START_RST;
      stop_q  <= STOP_RST;
      freq_q  <= FREQ_RST;
      step_q  <= STEP_RST;
    end else if (we) begin
      case (addr)
        A_CTRL:  ctrl_q  <= ctrl_t'(wdata[CTRL_W-1:0]);
        A_START: start_q <= wdata;
        A_STOP:  stop_q  <= wdata;
        A_FREQ:  freq_q  <= wdata;
        A_STEP:  step_q  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fan_pwm_timebase.sv
module fan_pwm_timebase
  import fan_ramp_pkg::*;
#(
  parameter int FAST_CYC = 1,
  parameter int SLOW_CYC = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] freq_q,
  output logic [REG_W-1:0] pwm_cnt,
  output logic             pwm_tick,
  output logic             period_end
);
  localparam int BASE_MAX = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int BASE_W   = $clog2(BASE_MAX + 1);
  localparam int DIV_W    = REG_W - 1;

  logic [BASE_W-1:0] pre_cnt, pre_lim;
  logic [DIV_W-1:0]  div_cnt, div_lim;
  logic              pre_tick;

  assign pre_lim  = freq_q[REG_W-1] ? BASE_W'(FAST_CYC - 1) : BASE_W'(SLOW_CYC - 1);
  assign div_lim  = (freq_q[DIV_W-1:0] == '0) ? '0 : freq_q[DIV_W-1:0] - 1'b1;
  assign pre_tick = (pre_cnt >= pre_lim);
  assign pwm_tick = pre_tick && (div_cnt >= div_lim);
  assign period_end = pwm_tick && (pwm_cnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      pwm_cnt <= '0;
    end else begin
      pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
      if (pre_tick) div_cnt <= (div_cnt >= div_lim) ? '0 : div_cnt + 1'b1;
      if (pwm_tick) pwm_cnt <= pwm_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fan_duty_ramp.sv
module fan_duty_ramp
  import fan_ramp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_end,
  input  ctrl_t             ctrl_q,
  input  logic [REG_W-1:0]  start_q,
  input  logic [REG_W-1:0]  stop_q,
  input  logic [REG_W-1:0]  step_q,
  input  logic [DUTY_W-1:0] speed_target,
  input  logic [DUTY_W-1:0] temp_target,
  input  logic [DUTY_W-1:0] manual_duty,
  output logic [DUTY_W-1:0] auto_target,
  output logic [DUTY_W-1:0] duty_q
);
  logic [DUTY_W-1:0] duty_next;
  logic [STEP_W-1:0] up_step, dn_step;

  assign up_step = step_q[REG_W-1:STEP_W];
  assign dn_step = step_q[STEP_W-1:0];
  assign auto_target = ctrl_q.mode[0] ? temp_target : speed_target;

  always_comb begin
    if (ctrl_q.full_latch)
      duty_next = '1;
    else if (ctrl_q.mode[1])
      duty_next = manual_duty;
    else
      duty_next = ramp_next(duty_q, auto_target, widen(start_q), widen(stop_q),
                            up_step, dn_step, ctrl_q.keep_stop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) duty_q <= '0;
    else if (period_end) duty_q <= duty_next;
  end
endmodule

// File: rtl/fan_duty_ctrl.sv
module fan_duty_ctrl
  import fan_ramp_pkg::*;
#(
  parameter int FAST_CYC = 1,
  parameter int SLOW_CYC = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [DUTY_W-1:0] speed_target,
  input  logic [DUTY_W-1:0] temp_target,
  input  logic [DUTY_W-1:0] manual_duty,
  output logic              pwm_out,
  output logic [DUTY_W-1:0] duty_level
);
  ctrl_t             ctrl_q;
  logic [REG_W-1:0]  start_q, stop_q, freq_q, step_q;
  logic [REG_W-1:0]  pwm_cnt;
  logic              pwm_tick, period_end;
  logic [DUTY_W-1:0] auto_target;

  fan_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl_q(ctrl_q), .start_q(start_q), .stop_q(stop_q), .freq_q(freq_q),
    .step_q(step_q)
  );

  fan_pwm_timebase #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)) u_time (
    .clk(clk), .rst_n(rst_n), .freq_q(freq_q), .pwm_cnt(pwm_cnt),
    .pwm_tick(pwm_tick), .period_end(period_end)
  );

  fan_duty_ramp u_ramp (
    .clk(clk), .rst_n(rst_n), .period_end(period_end), .ctrl_q(ctrl_q),
    .start_q(start_q), .stop_q(stop_q), .step_q(step_q),
    .speed_target(speed_target), .temp_target(temp_target),
    .manual_duty(manual_duty), .auto_target(auto_target), .duty_q(duty_level)
  );

  assign pwm_out = (pwm_cnt < duty_level[DUTY_W-1:LOW_W]);
endmodule

// File: rtl/fan_duty_ctrl_chk.sv
module fan_duty_ctrl_chk
  import fan_ramp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              period_end,
  input logic              pwm_out,
  input logic [REG_W-1:0]  pwm_cnt,
  input logic [DUTY_W-1:0] duty_level,
  input logic [DUTY_W-1:0] auto_target,
  input ctrl_t             ctrl_q,
  input logic [REG_W-1:0]  start_q,
  input logic [REG_W-1:0]  stop_q
);
  logic auto_mode;
  assign auto_mode = !ctrl_q.full_latch && !ctrl_q.mode[1];

  // R10
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(duty_level));

  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> pwm_cnt == '0);

  // R10
  zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    duty_level == '0 |-> !pwm_out);

  // R9
  full_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end && ctrl_q.full_latch |=> duty_level == '1);

  // R3
  spin_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end && auto_mode && duty_level == '0 && auto_target != '0 &&
    auto_target >= widen(stop_q) |=> duty_level == widen($past(start_q)));

  // R7
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end && auto_mode && ctrl_q.keep_stop && duty_level == widen(stop_q) &&
    (auto_target == '0 || auto_target < widen(stop_q)) |=> $stable(duty_level));
endmodule

bind fan_duty_ctrl fan_duty_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .period_end(period_end), .pwm_out(pwm_out),
  .pwm_cnt(pwm_cnt), .duty_level(duty_level), .auto_target(auto_target),
  .ctrl_q(ctrl_q), .start_q(start_q), .stop_q(stop_q)
);

// File: tb/fan_duty_ctrl_test.sv
`timescale 1ns/1ps
module fan_duty_ctrl_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cfg_we = 0;
  logic [2:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic [9:0] speed_target = 0, temp_target = 0, manual_duty = 0;
  logic       pwm_out;
  logic [9:0] duty_level;
  int checks = 0, fails = 0;
  logic [31:0] cyc;

  always #2 clk = ~clk;

  fan_duty_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .speed_target(speed_target), .temp_target(temp_target),
    .manual_duty(manual_duty), .pwm_out(pwm_out), .duty_level(duty_level)
  );

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Land on the negedge right after the next duty update edge.
  task automatic to_boundary();
    @(negedge clk);
    while (cyc[7:0] != 0) @(negedge clk);
  endtask

  task automatic count_high(output int n);
    n = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm_out) n++;
      @(negedge clk);
    end
  endtask

  // Expected automatic duty after one boundary, written from the rules.
  function automatic int model(int d, int t, int st, int sp, int u, int dn, bit keep);
    if (t == 0 || t < sp) begin
      if (d == 0) return 0;
      if (d <= sp) return keep ? d : 0;
      return (dn == 0 || d - dn <= sp) ? sp : d - dn;
    end
    if (d == 0) return st;
    if (d < t) return (u == 0 || d + u >= t) ? t : d + u;
    if (d > t) return (dn == 0 || d - dn <= t) ? t : d - dn;
    return d;
  endfunction

  task automatic t_reset();
    chk("R1 duty after reset", duty_level, 0);
    chk("R1 pin after reset", pwm_out, 0);
  endtask

  task automatic t_spin_up();
    int n;
    speed_target = 10'h200;
    to_boundary(); chk("R3 jump to default spin-up level", duty_level, 'h0C0);
    to_boundary(); chk("R8 zero up step reaches target", duty_level, 'h200);
    count_high(n); chk("R10 high count for 200h", n, 128);
  endtask

  task automatic t_ramp_up();
    wr(4, 'h40); speed_target = 10'h20A;
    to_boundary(); chk("R4 up step 1", duty_level, 'h204);
    to_boundary(); chk("R4 up step 2", duty_level, 'h208);
    to_boundary(); chk("R4 saturate at target", duty_level, 'h20A);
  endtask

  task automatic t_ramp_down();
    wr(4, 'h0F); speed_target = 10'h1F0;
    to_boundary(); chk("R5 down step", duty_level, 'h1FB);
    speed_target = 10'h1F0;
    repeat (100) @(negedge clk);
    speed_target = 10'h000;
    repeat (20) @(negedge clk);
    chk("R10 no change mid-period", duty_level, 'h1FB);
    speed_target = 10'h1F0;
    to_boundary(); chk("R5 saturate at target", duty_level, 'h1F0);
  endtask

  task automatic t_shutdown();
    wr(4, 'h00); speed_target = 0;
    to_boundary(); chk("R8 zero down step to stop level", duty_level, 'h094);
    to_boundary(); chk("R6 drop to zero", duty_level, 0);
    speed_target = 10'h050;
    to_boundary(); chk("R6 below-stop request keeps zero", duty_level, 0);
  endtask

  task automatic t_park();
    int e;
    speed_target = 10'h100;
    to_boundary(); to_boundary();
    chk("R3 restart", duty_level, 'h100);
    wr(0, 'h04); wr(4, 'h0F); speed_target = 0;
    e = 'h100;
    for (int i = 0; i < 10; i++) begin
      e = model(e, 0, 'h0C0, 'h094, 0, 15, 1);
      to_boundary(); chk("R7 ramp toward stop level", duty_level, e);
    end
    chk("R7 parked at stop level", duty_level, 'h094);
    wr(0, 'h00);
    to_boundary(); chk("R6 hold cleared drops to zero", duty_level, 0);
  endtask

  task automatic t_levels();
    wr(1, 'h60); wr(2, 'h40); wr(4, 'h00);
    speed_target = 10'h0C0;
    to_boundary(); chk("R6 request under new stop level stays zero", duty_level, 0);
    speed_target = 10'h200;
    to_boundary(); chk("R3 new spin-up level", duty_level, 'h180);
    to_boundary(); chk("R8 to target", duty_level, 'h200);
  endtask

  task automatic t_modes();
    temp_target = 10'h300; speed_target = 10'h100;
    wr(0, 'h01);
    to_boundary(); chk("R2 temperature source", duty_level, 'h300);
    speed_target = 10'h120;
    to_boundary(); chk("R2 speed input ignored", duty_level, 'h300);
    wr(4, 'h11); manual_duty = 10'h155; wr(0, 'h02);
    to_boundary(); chk("R2 manual direct", duty_level, 'h155);
    manual_duty = 10'h010; wr(0, 'h03);
    to_boundary(); chk("R2 manual 11 below stop no drop", duty_level, 'h010);
    wr(0, 'h12);
    to_boundary(); chk("R12 analog select no effect", duty_level, 'h010);
    manual_duty = 10'h2A0;
    to_boundary(); chk("R12 manual still applied", duty_level, 'h2A0);
  endtask

  task automatic t_full();
    int n;
    wr(0, 'h0A);
    to_boundary(); chk("R9 forced full", duty_level, 'h3FF);
    count_high(n); chk("R9 high count at full", n, 255);
    wr(0, 'h02);
    to_boundary(); chk("R9 released to manual", duty_level, 'h2A0);
  endtask

  task automatic period_of(output int n);
    realtime t0, t1;
    @(posedge pwm_out); @(posedge pwm_out);
    t0 = $realtime;
    @(posedge pwm_out);
    t1 = $realtime;
    n = int'((t1 - t0) / 4.0);
  endtask

  task automatic t_divider();
    int n;
    manual_duty = 10'h200;
    to_boundary();
    wr(3, 'h83); period_of(n); chk("R11 fast base div 3", n, 768);
    wr(3, 'h00); period_of(n); chk("R11 slow base div 0 as 1", n, 48 * 256);
    wr(3, 'h81); period_of(n); chk("R11 fast base div 1", n, 256);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_spin_up();
    t_ramp_up();
    t_ramp_down();
    t_shutdown();
    t_park();
    t_levels();
    t_modes();
    t_full();
    t_divider();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 190000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule